// File: doc/BRIEF.md
# Double-Buffered Bulk Endpoint Controller

This block tracks the ownership of two ping-pong packet buffers for one bulk endpoint of a full-speed device. The endpoint works either as a transmit (IN) endpoint or as a receive (OUT) endpoint. A 16-bit control register holds four things: the endpoint type, a kind bit that requests double buffering, a direction bit, and a completion flag for each direction. It also holds two toggle-only ownership bits. One of these bits is owned by hardware (the peripheral toggle) and the other by software (the application toggle). Which register bit plays which role depends on the direction.

From these two bits the block decodes two selects. One tells the serial engine which buffer-descriptor slot (address and count) it works on. The other tells the application which slot it may touch. The serial engine reports the end of each successful transaction with a pulse. The block then raises the completion flag and flips the peripheral toggle, so buffers swap without software action. When a token for the endpoint arrives and both toggles hold the same value, the peripheral has no free buffer, and the block latches a NAK answer.

Every pin is a plain control or status pin. No data stream passes through the block, so it has no valid/ready handshake and nothing can apply back-pressure. The register is read combinationally through `reg_rdata`. It is written in a single cycle through `reg_wr_en` and `reg_wdata`.

Top module: `ep_dbuf_ctrl`

## Requirements
- R1: Double buffering is active only while the type field (bits 10:9) reads 2'b00 and the kind bit (bit 8) reads 1. Any other type value, or kind 0, makes it inactive.
- R2: The direction bit (bit 0) selects the role of each toggle bit. When it is 1 (IN), the peripheral toggle is bit 6 and the application toggle is bit 14. When it is 0 (OUT), the peripheral toggle is bit 14 and the application toggle is bit 6. While the block is active, `periph_slot` equals the peripheral toggle and `app_slot` equals the application toggle, where 0 means descriptor slot 0 and 1 means slot 1.
- R3: Bits 14 and 6 are toggle-only for software. Writing 1 inverts the bit and writing 0 leaves it unchanged.
- R4: A `xfer_done` pulse sets the transmit flag (bit 7) when the direction bit is 1, or the receive flag (bit 15) when it is 0. The flag is visible from the next cycle. Software clears a flag by writing 0 and leaves it unchanged by writing 1. If a hardware set and a software clear fall in the same cycle, the set wins.
- R5: While the block is active, every `xfer_done` inverts the peripheral toggle. If software writes 1 to that same bit in the same cycle, the two inversions cancel and the bit keeps its value.
- R6: Flow control arms on the first `xfer_done` seen while the block is active. Once armed, a `tok_valid` cycle in which the two toggles are equal makes `nak` 1 from the next cycle, and a `tok_valid` cycle in which they differ makes it 0. Without `tok_valid`, `nak` holds its value.
- R7: Flow control disarms in any cycle in which the block is inactive. After that, it re-arms only on a later `xfer_done` seen while the block is active. Before it re-arms, a token gives `nak` 0.
- R8: While the block is inactive, both slot selects are 0, `xfer_done` does not change either toggle bit, and a token gives `nak` 0.
- R9: After reset, the register reads 0x0000, both slot selects are 0 and `nak` is 0.
- R10: The type, kind and direction fields take the written value directly. All other register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register image |
| tok_valid | input | 1 | A token addressed to this endpoint arrives |
| xfer_done | input | 1 | Successful end of a transaction |
| nak | output | 1 | Latched answer to the last token (1 = NAK) |
| periph_slot | output | 1 | Descriptor slot the serial engine uses |
| app_slot | output | 1 | Descriptor slot the application uses |

## Verification
The risky collisions happen when a register write lands in the same cycle as a `xfer_done`. A write of 1 to the peripheral toggle can coincide with the hardware flip, and a flag clear can coincide with the hardware set. The directed part of the bench forces both collisions and expects the toggle unchanged and the flag set. The random part drives writes, completions and tokens independently, often in the same cycle, so the collisions also appear in both directions and under mode changes. A bench model built from the requirements predicts the register image, the selects and `nak` in every cycle, and the bench compares the outputs against it.

// File: rtl/ep_dbuf_pkg.sv
package ep_dbuf_pkg;
  localparam int REG_W      = 16;
  localparam int TYPE_W     = 2;
  localparam int TYPE_LSB   = 9;
  localparam int KIND_POS   = 8;
  localparam int DIR_POS    = 0;
  localparam int LANES      = 2;   // lane 0: bit 6 / tx flag, lane 1: bit 14 / rx flag
  localparam int TOG_POS_LO = 6;
  localparam int TOG_POS_HI = 14;
  localparam int FLG_POS_LO = 7;
  localparam int FLG_POS_HI = 15;
  localparam logic [TYPE_W-1:0] TYPE_BULK = '0;

  typedef struct packed {
    logic [TYPE_W-1:0] ep_type;
    logic              kind;
    logic              is_in;
  } ep_cfg_t;

  function automatic int tog_pos(input int lane);
    return (lane == 0) ? TOG_POS_LO : TOG_POS_HI;
  endfunction

  function automatic int flg_pos(input int lane);
    return (lane == 0) ? FLG_POS_LO : FLG_POS_HI;
  endfunction
endpackage

// File: rtl/ep_ctrl_regs.sv
module ep_ctrl_regs
  import ep_dbuf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_W-1:0]        wdata,
  input  logic [LANES-1:0]        hw_flip,   // hardware inversion per toggle lane
  input  logic [LANES-1:0]        hw_set,    // hardware flag set per lane
  output ep_cfg_t                 cfg,
  output logic [LANES-1:0]        tog,
  output logic [LANES-1:0]        flg,
  output logic [REG_W-1:0]        rdata
);
  // configuration fields: plain write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.ep_type <= wdata[TYPE_LSB +: TYPE_W];
      cfg.kind    <= wdata[KIND_POS];
      cfg.is_in   <= wdata[DIR_POS];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int TP = tog_pos(g);
    localparam int FP = flg_pos(g);
    logic sw_flip;
    logic sw_clr;

    assign sw_flip = wr_en & wdata[TP];
    assign sw_clr  = wr_en & ~wdata[FP];

    // toggle-only bit: software and hardware inversions compose by XOR
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog[g] <= 1'b0;
      else        tog[g] <= tog[g] ^ sw_flip ^ hw_flip[g];
    end

    // completion flag: hardware set has priority over software clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flg[g] <= 1'b0;
      else if (hw_set[g]) flg[g] <= 1'b1;
      else if (sw_clr)    flg[g] <= 1'b0;
    end

    assert_tog_write0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_flip && !hw_flip[g]) |=> $stable(tog[g]));
    assert_tog_write1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_flip && !hw_flip[g]) |=> (tog[g] != $past(tog[g])));
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[g] |=> flg[g]);
    assert_flag_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flg[g] && !sw_clr) |=> flg[g]);
  end

  always_comb begin
    rdata = '0;
    rdata[TYPE_LSB +: TYPE_W] = cfg.ep_type;
    rdata[KIND_POS]           = cfg.kind;
    rdata[DIR_POS]            = cfg.is_in;
    for (int i = 0; i < LANES; i++) begin
      rdata[tog_pos(i)] = tog[i];
      rdata[flg_pos(i)] = flg[i];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[5:1], wdata[13:11]};
endmodule

// File: rtl/ep_slot_decode.sv
module ep_slot_decode
  import ep_dbuf_pkg::*;
(
  input  ep_cfg_t          cfg,
  input  logic [LANES-1:0] tog,
  output logic             dbl_act,
  output logic             dtog_lane,   // lane index holding the peripheral toggle
  output logic             periph_slot,
  output logic             app_slot,
  output logic             clash
);
  logic dtog;
  logic swbuf;

  assign dbl_act   = (cfg.ep_type == TYPE_BULK) && cfg.kind;
  assign dtog_lane = ~cfg.is_in;                  // IN: lane 0 (bit 6), OUT: lane 1 (bit 14)
  assign dtog      = cfg.is_in ? tog[0] : tog[1];
  assign swbuf     = cfg.is_in ? tog[1] : tog[0];

  assign periph_slot = dbl_act & dtog;
  assign app_slot    = dbl_act & swbuf;
  assign clash       = (dtog == swbuf);
endmodule

// File: rtl/ep_flow_ctrl.sv
module ep_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_act,
  input  logic xfer_done,
  input  logic tok_valid,
  input  logic clash,
  output logic hw_toggle,
  output logic nak
);
  logic armed;

  assign hw_toggle = dbl_act & xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (!dbl_act)   armed <= 1'b0;
    else if (xfer_done)  armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nak <= 1'b0;
    else if (tok_valid) nak <= dbl_act & armed & clash;
  end

  assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_act |=> !armed);
  assert_nak_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !armed) |=> !nak);
  assert_nak_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> $stable(nak));
  assert_nak_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !clash) |=> !nak);
endmodule

// File: rtl/ep_dbuf_ctrl.sv
module ep_dbuf_ctrl
  import ep_dbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tok_valid,
  input  logic             xfer_done,
  output logic             nak,
  output logic             periph_slot,
  output logic             app_slot
);
  ep_cfg_t          cfg;
  logic [LANES-1:0] tog;
  logic [LANES-1:0] flg;
  logic [LANES-1:0] hw_flip;
  logic [LANES-1:0] hw_set;
  logic             dbl_act;
  logic             dtog_lane;
  logic             clash;
  logic             hw_toggle;

  // lane 0 carries the transmit flag, lane 1 the receive flag
  assign hw_set  = {xfer_done & ~cfg.is_in, xfer_done & cfg.is_in};
  assign hw_flip = {hw_toggle & dtog_lane, hw_toggle & ~dtog_lane};

  ep_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wdata   (reg_wdata),
    .hw_flip (hw_flip),
    .hw_set  (hw_set),
    .cfg     (cfg),
    .tog     (tog),
    .flg     (flg),
    .rdata   (reg_rdata)
  );

  ep_slot_decode u_dec (
    .cfg         (cfg),
    .tog         (tog),
    .dbl_act     (dbl_act),
    .dtog_lane   (dtog_lane),
    .periph_slot (periph_slot),
    .app_slot    (app_slot),
    .clash       (clash)
  );

  ep_flow_ctrl u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_act   (dbl_act),
    .xfer_done (xfer_done),
    .tok_valid (tok_valid),
    .clash     (clash),
    .hw_toggle (hw_toggle),
    .nak       (nak)
  );

  assert_hw_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_act && xfer_done && !reg_wr_en) |=> (periph_slot != $past(periph_slot)));
  assert_idle_no_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_act && !reg_wr_en) |=> $stable(tog));
  assert_idle_slots_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_act |-> (!periph_slot && !app_slot));
  assert_flag_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> $countones(flg & $past(hw_set)) == 1);
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[5:1] == '0) && (reg_rdata[13:11] == '0));
endmodule

// File: tb/ep_dbuf_ctrl_tb_top.sv
module ep_dbuf_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tok_valid = 1'b0;
  logic        xfer_done = 1'b0;
  logic        nak, periph_slot, app_slot;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [15:0] m_reg = '0;
  logic        m_armed = 1'b0;
  logic        m_nak = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_dbuf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tok_valid(tok_valid), .xfer_done(xfer_done),
    .nak(nak), .periph_slot(periph_slot), .app_slot(app_slot)
  );

  function automatic logic f_act(input logic [15:0] r);
    return (r[10:9] == 2'b00) && r[8];
  endfunction
  function automatic logic f_dtog(input logic [15:0] r);
    return r[0] ? r[6] : r[14];
  endfunction
  function automatic logic f_sw(input logic [15:0] r);
    return r[0] ? r[14] : r[6];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model one clock edge from requirements R1..R8
  task automatic model_step(input logic wr, input logic [15:0] wd, input logic done, input logic tok);
    logic [15:0] n;
    logic act;
    act = f_act(m_reg);
    n = m_reg;
    if (tok) m_nak = act && m_armed && (f_dtog(m_reg) == f_sw(m_reg));
    if (wr) begin
      n[10:9] = wd[10:9]; n[8] = wd[8]; n[0] = wd[0];
      n[14] = n[14] ^ wd[14];
      n[6]  = n[6] ^ wd[6];
      if (!wd[7])  n[7] = 1'b0;
      if (!wd[15]) n[15] = 1'b0;
    end
    if (done) begin
      if (m_reg[0]) n[7] = 1'b1; else n[15] = 1'b1;
      if (act) begin
        if (m_reg[0]) n[6] = ~n[6]; else n[14] = ~n[14];
      end
    end
    if (!act) m_armed = 1'b0; else if (done) m_armed = 1'b1;
    m_reg = n;
  endtask

  // called at a falling edge: drive, clock, return at the next falling edge
  task automatic cycle(input logic wr, input logic [15:0] wd, input logic done, input logic tok);
    reg_wr_en = wr; reg_wdata = wd; xfer_done = done; tok_valid = tok;
    model_step(wr, wd, done, tok);
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; xfer_done = 1'b0; tok_valid = 1'b0;
  endtask

  task automatic check_model(input string tag);
    logic act;
    act = f_act(m_reg);
    chk({tag, " R3/R4/R5/R10 rdata"}, reg_rdata, m_reg);
    chk({tag, " R2/R8 slots"}, {14'd0, periph_slot, app_slot},
        {14'd0, act & f_dtog(m_reg), act & f_sw(m_reg)});
    chk({tag, " R6/R7 nak"}, {15'd0, nak}, {15'd0, m_nak});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rdata after reset", reg_rdata, 16'h0000);
    chk("R9 slots after reset", {14'd0, periph_slot, app_slot}, 16'h0000);
    chk("R9 nak after reset", {15'd0, nak}, 16'h0000);

    // IN endpoint, bulk, kind=1, flip application toggle (bit 14)
    cycle(1'b1, 16'h4101, 1'b0, 1'b0);
    chk("R1/R3 rdata IN config", reg_rdata, 16'h4101);
    chk("R2 IN slots periph=0 app=1", {14'd0, periph_slot, app_slot}, 16'h0001);
    // R6 token before arming
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R6 nak before arm", {15'd0, nak}, 16'h0000);
    // completion: flag bit 7 set, bit 6 flipped
    cycle(1'b0, '0, 1'b1, 1'b0);
    chk("R4/R5 completion IN", reg_rdata, 16'h41C1);
    chk("R2 slots after flip", {14'd0, periph_slot, app_slot}, 16'h0003);
    // R6 toggles equal and armed: NAK
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R6 nak on clash", {15'd0, nak}, 16'h0001);
    cycle(1'b0, '0, 1'b0, 1'b0);
    chk("R6 nak held without token", {15'd0, nak}, 16'h0001);
    // R3 software flips application toggle, writes 1 to flag (kept)
    cycle(1'b1, 16'h4181, 1'b0, 1'b1);
    chk("R3/R4 sw flip, flag kept", reg_rdata, 16'h01C1);
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R6 nak cleared when free", {15'd0, nak}, 16'h0000);
    // R3/R4 write zeros: toggles unchanged, flag cleared
    cycle(1'b1, 16'h0101, 1'b0, 1'b0);
    chk("R3/R4 write 0 clears flag only", reg_rdata, 16'h0141);
    // R4/R5 completion and flag clear in same cycle: set wins
    cycle(1'b1, 16'h0101, 1'b1, 1'b0);
    chk("R4 set beats clear", reg_rdata, 16'h0181);
    // R5 completion and sw flip of peripheral toggle cancel
    cycle(1'b1, 16'h0141, 1'b1, 1'b0);
    chk("R5 sw and hw flips cancel", reg_rdata, 16'h0181);
    // R8 kind cleared: inactive
    cycle(1'b1, 16'h4081, 1'b0, 1'b0);
    chk("R8 slots zero when inactive", {14'd0, periph_slot, app_slot}, 16'h0000);
    cycle(1'b0, '0, 1'b1, 1'b1);
    chk("R8 no hw flip when inactive", reg_rdata, 16'h4081);
    chk("R8 nak zero when inactive", {15'd0, nak}, 16'h0000);
    // R7 re-enable: disarmed, toggles differ? bit14=1, bit6=0 -> flip bit6 to clash
    cycle(1'b1, 16'h0141, 1'b0, 1'b0);
    cycle(1'b0, '0, 1'b0, 1'b1);
    chk("R7 no nak before re-arm", {15'd0, nak}, 16'h0000);
    // R1 type 01 with kind set is inactive
    cycle(1'b1, 16'h0381, 1'b0, 1'b0);
    chk("R1 non-bulk type inactive", {14'd0, periph_slot, app_slot}, 16'h0000);
    // R2 OUT direction: bit 14 is peripheral toggle
    cycle(1'b1, 16'h0100, 1'b0, 1'b0);
    check_model("directed OUT");
    cycle(1'b0, '0, 1'b1, 1'b0);
    check_model("directed OUT done");

    // constrained random
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [15:0] wd;
      logic wr, dn, tk;
      wr = ($urandom % 5) == 0;
      dn = ($urandom % 3) == 0;
      tk = ($urandom % 2) == 0;
      wd = 16'($urandom);
      if (($urandom % 8) != 0) wd[10:9] = 2'b00;
      wd[8] = ($urandom % 10) != 0;
      cycle(wr, wd, dn, tk);
      check_model("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule